// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the device-side command engine that a byte-wide NAND-style flash die uses to run block erase, including pausing an erase and continuing it later. The host writes bytes on an 8-bit bus; each byte is taken when the write strobe rises. A command-latch qualifier marks a byte as a command and an address-latch qualifier marks it as an address. The strobe is sampled on the system clock, so a rising edge is a clock where the strobe is high and was low on the clock before.

An erase is started by a setup command, two address bytes and a confirm command. The erase duration is modelled by a down-counter loaded with a parameter number of clock cycles. While the erase runs, the ready output is low and the status byte reports busy. Only a small set of commands is honoured in that time. A suspended erase holds its remaining count and its block number. Outside logic uses the access port to learn whether a read or program to a given block may go ahead.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `ready_o` is 1, `status_o` is 8'h40 (bit 6 = ready, bit 5 = suspended, bit 0 = erase failed, other bits 0), `erase_act_o` is 0 and `suspended_o` is 0.
- R2: The command bytes 60h, then two address bytes, then the command byte D0h start an erase on the clock edge that sees the D0h strobe. `ready_o` is 0 from the next cycle on. Any other command that arrives before the sequence is complete drops it, and no erase starts.
- R3: The erased block number is {second address byte bits [5:0], first address byte bits [7:4]}. It is shown on `erase_blk_o` while `erase_act_o` is 1. First-byte bits [3:0] and second-byte bits [7:6] have no effect.
- R4: An erase that is not suspended keeps `ready_o` low for exactly ERASE_CYC cycles. After that, `ready_o` is 1, `status_o` bit 0 is 0 and `erase_act_o` is 0.
- R5: While the erase is busy, every command except B0h, FFh and 70h is ignored, and so are address bytes. A 60h sent then does not arm a new sequence.
- R6: B0h sent during a busy erase suspends it. `ready_o` returns to 1 and `suspended_o` and `status_o` bit 5 become 1. B0h sent while idle has no effect.
- R7: The remaining erase time stays frozen while the erase is suspended. The busy cycles before the suspend and after the resume add up to ERASE_CYC.
- R8: D0h sent while suspended resumes the same block. D0h sent while idle starts nothing.
- R9: While suspended, a 60h setup is rejected, and the address bytes that follow it do not change `erase_blk_o`.
- R10: FFh during a busy or suspended erase aborts it. From the next cycle `ready_o` is 1, `erase_act_o` is 0 and `status_o` bit 0 is 1. FFh in any other state clears status bit 0.
- R11: `access_ok_o` is 0 while an erase is busy. While suspended it is 1 only when `access_blk_i` differs from `erase_blk_o`. With no erase active it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb_i | input | 1 | Host write strobe, byte taken on its rising edge |
| cmd_lat_i | input | 1 | Byte is a command |
| adr_lat_i | input | 1 | Byte is an address |
| bus_i | input | 8 | Host byte bus |
| access_blk_i | input | BLK_W | Block a read or program wants to touch |
| ready_o | output | 1 | 1 = ready, 0 = erase running |
| status_o | output | 8 | Status byte: bit 6 ready, bit 5 suspended, bit 0 fail |
| erase_act_o | output | 1 | An erase is running or suspended |
| suspended_o | output | 1 | The erase is suspended |
| erase_blk_o | output | BLK_W | Block being erased |
| access_ok_o | output | 1 | Access to `access_blk_i` is allowed |

## Verification
The bench builds the block with ERASE_CYC set to 20 and leaves the block width and the strobe path at their defaults. The short erase means that full erases, suspends part-way through the count, long pauses while suspended and aborts all fit in a few hundred cycles. It also means the bench can count the exact number of busy cycles on both sides of a suspend, which would be out of reach at a realistic millisecond count.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_ADR1  = 3'd2,
      ST_ADR2  = 3'd3,
      ST_BUSY  = 3'd4,
      ST_SUSP  = 3'd5
   } seq_state_t;

   localparam logic [7:0] OP_SETUP   = 8'h60;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_PAUSE   = 8'hB0;
   localparam logic [7:0] OP_ABORT   = 8'hFF;
   localparam logic [7:0] OP_STATUS  = 8'h70;

   localparam int STS_FAIL  = 0;
   localparam int STS_SUSP  = 5;
   localparam int STS_READY = 6;
endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge #(
   parameter bit PIPE_IN = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb_i,
   input  logic       cmd_i,
   input  logic       adr_i,
   input  logic [7:0] bus_i,
   output logic       cmd_p_o,
   output logic       adr_p_o,
   output logic [7:0] byte_o
);
   logic       stb_s, cmd_s, adr_s;
   logic [7:0] bus_s;
   logic       stb_q;

   generate
      if (PIPE_IN) begin : g_pipe
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stb_s <= 1'b0;
               cmd_s <= 1'b0;
               adr_s <= 1'b0;
               bus_s <= '0;
            end else begin
               stb_s <= stb_i;
               cmd_s <= cmd_i;
               adr_s <= adr_i;
               bus_s <= bus_i;
            end
         end
      end else begin : g_direct
         always_comb begin
            stb_s = stb_i;
            cmd_s = cmd_i;
            adr_s = adr_i;
            bus_s = bus_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb_s;
   end

   logic rise;
   assign rise    = stb_s & ~stb_q;
   assign cmd_p_o = rise & cmd_s & ~adr_s;
   assign adr_p_o = rise & adr_s & ~cmd_s;
   assign byte_o  = bus_s;
endmodule

// File: rtl/flash_blk_capture.sv
module flash_blk_capture #(
   parameter int BLK_W   = 10,
   parameter int LO_KEEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_lo_i,
   input  logic             take_hi_i,
   input  logic [7:0]       byte_i,
   output logic [BLK_W-1:0] blk_o
);
   localparam int HI_KEEP = BLK_W - LO_KEEP;

   logic [LO_KEEP-1:0] lo_q;
   logic [HI_KEEP-1:0] hi_q;

   initial begin
      assert (LO_KEEP >= 1 && LO_KEEP <= 8) else $error("LO_KEEP out of range");
      assert (HI_KEEP >= 1 && HI_KEEP <= 8) else $error("BLK_W does not fit two bytes");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (take_lo_i) lo_q <= byte_i[7 -: LO_KEEP];
         if (take_hi_i) hi_q <= byte_i[HI_KEEP-1:0];
      end
   end

   assign blk_o = {hi_q, lo_q};
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
   parameter int ERASE_CYC = 500000,
   parameter int CNT_W     = $clog2(ERASE_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ERASE_CYC);

   initial begin
      assert (ERASE_CYC >= 1) else $error("ERASE_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_o <= '0;
      else if (load_i)               cnt_o <= LOAD_VAL;
      else if (run_i && cnt_o != '0) cnt_o <= cnt_o - 1'b1;
   end

   assign last_o = (cnt_o == CNT_W'(1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import flash_erase_pkg::*;
#(
   parameter int BLK_W     = 10,
   parameter int LO_KEEP   = 4,
   parameter int ERASE_CYC = 500000,
   parameter bit PIPE_IN   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb_i,
   input  logic             cmd_lat_i,
   input  logic             adr_lat_i,
   input  logic [7:0]       bus_i,
   input  logic [BLK_W-1:0] access_blk_i,
   output logic             ready_o,
   output logic [7:0]       status_o,
   output logic             erase_act_o,
   output logic             suspended_o,
   output logic [BLK_W-1:0] erase_blk_o,
   output logic             access_ok_o
);
   localparam int CNT_W = $clog2(ERASE_CYC + 1);

   seq_state_t       state_q;
   logic             fail_q;
   logic             cmd_p, adr_p;
   logic [7:0]       byte_v;
   logic             take_lo, take_hi, start, last;
   logic [CNT_W-1:0] cnt;

   flash_strobe_edge #(.PIPE_IN(PIPE_IN)) u_edge (
      .clk(clk), .rst_n(rst_n), .stb_i(wr_stb_i), .cmd_i(cmd_lat_i),
      .adr_i(adr_lat_i), .bus_i(bus_i), .cmd_p_o(cmd_p), .adr_p_o(adr_p),
      .byte_o(byte_v)
   );

   assign take_lo = adr_p && (state_q == ST_SETUP);
   assign take_hi = adr_p && (state_q == ST_ADR1);
   assign start   = cmd_p && (state_q == ST_ADR2) && (byte_v == OP_CONFIRM);

   flash_blk_capture #(.BLK_W(BLK_W), .LO_KEEP(LO_KEEP)) u_cap (
      .clk(clk), .rst_n(rst_n), .take_lo_i(take_lo), .take_hi_i(take_hi),
      .byte_i(byte_v), .blk_o(erase_blk_o)
   );

   flash_erase_timer #(.ERASE_CYC(ERASE_CYC), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(start),
      .run_i(state_q == ST_BUSY), .cnt_o(cnt), .last_o(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fail_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_BUSY: begin
               if (cmd_p && byte_v == OP_ABORT) begin
                  state_q <= ST_IDLE;
                  fail_q  <= 1'b1;
               end else if (last) begin
                  state_q <= ST_IDLE;
                  fail_q  <= 1'b0;
               end else if (cmd_p && byte_v == OP_PAUSE) begin
                  state_q <= ST_SUSP;
               end
            end
            ST_SUSP: begin
               if (cmd_p && byte_v == OP_ABORT) begin
                  state_q <= ST_IDLE;
                  fail_q  <= 1'b1;
               end else if (cmd_p && byte_v == OP_CONFIRM) begin
                  state_q <= ST_BUSY;
               end
            end
            default: begin
               if (cmd_p) begin
                  if (byte_v == OP_ABORT) fail_q <= 1'b0;
                  if (start) begin
                     state_q <= ST_BUSY;
                     fail_q  <= 1'b0;
                  end else if (byte_v == OP_SETUP) begin
                     state_q <= ST_SETUP;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else if (take_lo) begin
                  state_q <= ST_ADR1;
               end else if (take_hi) begin
                  state_q <= ST_ADR2;
               end
            end
         endcase
      end
   end

   assign ready_o     = (state_q != ST_BUSY);
   assign suspended_o = (state_q == ST_SUSP);
   assign erase_act_o = (state_q == ST_BUSY) || (state_q == ST_SUSP);

   always_comb begin
      status_o            = '0;
      status_o[STS_READY] = ready_o;
      status_o[STS_SUSP]  = suspended_o;
      status_o[STS_FAIL]  = fail_q;
   end

   always_comb begin
      if (state_q == ST_BUSY)      access_ok_o = 1'b0;
      else if (state_q == ST_SUSP) access_ok_o = (access_blk_i != erase_blk_o);
      else                         access_ok_o = 1'b1;
   end

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready_o);

   assert_susp_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SUSP) |=> $stable(cnt));

   assert_busy_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUSY && !last && !(cmd_p && byte_v == OP_ABORT)) |=> (cnt == $past(cnt) - 1'b1));

   assert_blk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_act_o && $past(erase_act_o)) |-> $stable(erase_blk_o));

   assert_abort_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_p && byte_v == OP_ABORT && erase_act_o) |=> (ready_o && status_o[STS_FAIL] && !erase_act_o));

   always_comb begin
      if (rst_n && suspended_o && access_ok_o)
         assert_access_other_R11: assert (access_blk_i != erase_blk_o);
   end
endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
   localparam int BW  = 10;
   localparam int CYC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0, cmd_lat = 1'b0, adr_lat = 1'b0;
   logic [7:0]    bus = '0;
   logic [BW-1:0] acc_blk = '0;
   logic          ready, act, susp, acc_ok;
   logic [7:0]    status;
   logic [BW-1:0] blk;

   int checks = 0, errors = 0;
   int busy_cnt = 0;

   always #2 clk = ~clk;

   flash_erase_seq #(.BLK_W(BW), .LO_KEEP(4), .ERASE_CYC(CYC), .PIPE_IN(1'b0)) u_flash_erase_seq (
      .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .cmd_lat_i(cmd_lat),
      .adr_lat_i(adr_lat), .bus_i(bus), .access_blk_i(acc_blk),
      .ready_o(ready), .status_o(status), .erase_act_o(act),
      .suspended_o(susp), .erase_blk_o(blk), .access_ok_o(acc_ok)
   );

   always @(negedge clk) if (rst_n && !ready) busy_cnt++;

   task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
      end
   endtask

   task automatic wr(input bit c, input bit a, input logic [7:0] d);
      @(negedge clk);
      cmd_lat = c; adr_lat = a; bus = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; cmd_lat = 1'b0; adr_lat = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] d); wr(1'b1, 1'b0, d); endtask
   task automatic adr(input logic [7:0] d); wr(1'b0, 1'b1, d); endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_ready;
      for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
   endtask

   task automatic start_erase(input logic [7:0] a1, input logic [7:0] a2);
      busy_cnt = 0;
      cmd(8'h60); adr(a1); adr(a2); cmd(8'hD0);
   endtask

   task automatic t_reset;
      chk(ready === 1'b1 && status === 8'h40 && act === 1'b0 && susp === 1'b0,
          "R1 reset state", status, 8'h40);
   endtask

   task automatic t_full_erase;
      start_erase(8'hA7, 8'hD5);
      chk(ready === 1'b0 && status === 8'h00, "R2 busy after confirm", status, 8'h00);
      chk(blk === 10'h15A && act === 1'b1, "R3 block number", blk, 10'h15A);
      acc_blk = 10'h15A; #1;
      chk(acc_ok === 1'b0, "R11 no access while busy", acc_ok, 0);
      wait_ready;
      chk(busy_cnt == CYC, "R4 busy length", busy_cnt, CYC);
      chk(status === 8'h40 && act === 1'b0, "R4 done status", status, 8'h40);
      acc_blk = 10'h15A; #1;
      chk(acc_ok === 1'b1, "R11 access when idle", acc_ok, 1);
   endtask

   task automatic t_ignored_bits;
      start_erase(8'hAF, 8'h15);
      chk(blk === 10'h15A, "R3 ignored address bits", blk, 10'h15A);
      wait_ready;
      start_erase(8'h3F, 8'h3C);
      chk(blk === 10'h3C3, "R3 second block", blk, 10'h3C3);
      wait_ready;
   endtask

   task automatic t_broken_seq;
      busy_cnt = 0;
      cmd(8'h60); cmd(8'hD0);
      idle(3);
      chk(ready === 1'b1 && busy_cnt == 0, "R2 short sequence dropped", busy_cnt, 0);
      cmd(8'h60); adr(8'h10); cmd(8'h70); adr(8'h01); cmd(8'hD0);
      idle(3);
      chk(ready === 1'b1 && act === 1'b0, "R2 interrupted sequence dropped", ready, 1);
      cmd(8'hD0); idle(2);
      chk(ready === 1'b1 && act === 1'b0, "R8 confirm in idle ignored", act, 0);
      cmd(8'hB0); idle(2);
      chk(susp === 1'b0 && status === 8'h40, "R6 pause in idle ignored", status, 8'h40);
   endtask

   task automatic t_busy_ignore;
      start_erase(8'h20, 8'h01);
      cmd(8'h60); adr(8'h50); cmd(8'h70); adr(8'h02);
      wait_ready;
      chk(busy_cnt == CYC && blk === 10'h012, "R5 commands ignored while busy", busy_cnt, CYC);
      busy_cnt = 0;
      adr(8'h00); adr(8'h00); cmd(8'hD0); idle(2);
      chk(ready === 1'b1 && busy_cnt == 0, "R5 setup during busy not armed", busy_cnt, 0);
   endtask

   task automatic t_suspend_resume;
      start_erase(8'h50, 8'h02);
      idle(5);
      cmd(8'hB0);
      chk(ready === 1'b1 && susp === 1'b1 && status === 8'h60, "R6 suspended", status, 8'h60);
      idle(40);
      chk(susp === 1'b1 && ready === 1'b1, "R7 stays suspended", susp, 1);
      acc_blk = 10'h025; #1;
      chk(acc_ok === 1'b0, "R11 erased block blocked", acc_ok, 0);
      acc_blk = 10'h026; #1;
      chk(acc_ok === 1'b1, "R11 other block allowed", acc_ok, 1);
      cmd(8'h60); adr(8'hF0); adr(8'h3F);
      chk(susp === 1'b1 && blk === 10'h025, "R9 setup rejected while suspended", blk, 10'h025);
      cmd(8'hD0);
      chk(ready === 1'b0 && blk === 10'h025, "R8 resume same block", blk, 10'h025);
      wait_ready;
      chk(busy_cnt == CYC, "R7 total busy cycles", busy_cnt, CYC);
      chk(status === 8'h40, "R7 completed after resume", status, 8'h40);
   endtask

   task automatic t_abort;
      start_erase(8'h70, 8'h03);
      idle(4);
      cmd(8'hFF);
      chk(ready === 1'b1 && act === 1'b0 && status === 8'h41, "R10 abort busy", status, 8'h41);
      cmd(8'hFF);
      chk(status === 8'h40, "R10 reset clears fail", status, 8'h40);
      start_erase(8'h70, 8'h03);
      idle(3);
      cmd(8'hB0);
      cmd(8'hFF);
      chk(act === 1'b0 && susp === 1'b0 && status === 8'h41, "R10 abort suspended", status, 8'h41);
      start_erase(8'h00, 8'h00);
      wait_ready;
      chk(status === 8'h40, "R4 new erase clears fail", status, 8'h40);
   endtask

   initial begin
      fork
         begin
            idle(3);
            rst_n = 1'b1;
            idle(2);
            t_reset;
            t_full_erase;
            t_ignored_bits;
            t_broken_seq;
            t_busy_ignore;
            t_suspend_resume;
            t_abort;
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule